// File: doc/BRIEF.md
# Call-Return Stack Sequencer

This block carries out the control-transfer operations that must save or restore machine state: subroutine call (absolute or PC-relative target), software interrupt (8-bit vector target), return, and return from interrupt. It owns the program counter, the stack pointer and the flags register. It moves PC and flags through a stack that grows towards lower addresses, using a single-port memory with an address, write data, read data, and separate read and write strobes.

A decoder elsewhere pulses `start` with an operation code and a 16-bit operand. For the register forms of call, the decoder supplies the register value as the operand. Every operation runs a fixed execute phase of eight cycles. The last of these cycles is marked by a one-cycle `done`. Memory read data is taken one cycle after the read strobe. The stack accesses follow a fixed interleaving with the SP updates, so that a return undoes a call step for step.

Top module: `callret_seq`

## Requirements
- R1: After reset, pc is 0x0000, sp is 0xFFFF, flags is 0, int_en is 0, busy is 0, and neither memory strobe is active.
- R2: A start pulse seen while idle begins an operation. busy stays high for exactly 8 cycles, and done is high only in the 8th. A start seen while busy is ignored.
- R3: Operation codes 0, 1 and 4 save state. In cycle 0 they write pc to address sp. In cycle 1 they decrement sp. In cycle 2 they write flags, zero-extended to 16 bits, to the new sp. In cycle 3 they decrement sp again. The net change is sp - 2.
- R4: Code 0 (absolute call) loads pc with the operand. Code 1 (relative call) loads pc with pc + operand, modulo 2^16.
- R5: Code 4 (software interrupt) loads pc with the low 8 bits of the operand, zero-extended. Operand bits 15:8 have no effect.
- R6: Code 2 (return) restores state. In cycle 0 it increments sp. In cycle 1 it reads address sp, and flags takes the low 4 bits of the word returned in the next cycle. In cycle 3 it increments sp again. In cycle 4 it reads address sp, and pc takes the full word returned. It performs no writes.
- R7: Code 3 (return from interrupt) behaves like code 2 and also sets int_en at the end of the operation. No other code changes int_en.
- R8: flags change only through the reads of a return. Calls and software interrupts leave them unchanged.
- R9: The read and write strobes are never active together, and neither is active while idle.
- R10: Codes 5, 6 and 7 still take 8 cycles, but make no memory access and change neither pc, sp, flags nor int_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 3 | Operation code: 0 call, 1 relative call, 2 return, 3 return from interrupt, 4 software interrupt |
| operand | input | 16 | Target address, offset or vector |
| busy | output | 1 | Execute phase in progress |
| done | output | 1 | Last execute cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| flags | output | 4 | Flags register |
| int_en | output | 1 | Interrupt enable |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 16 | Stack write data |
| mem_rdata | input | 16 | Stack read data, valid the cycle after mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
The bench nests a dozen saving operations and then unwinds them, and it logs the cycle and address of every memory strobe. A design that decremented SP before the first write, or that read before incrementing, would show up at once as misplaced stack addresses. A relative call with a negative offset and one whose sum wraps past 0xFFFF catches a missing modulo, and a software interrupt with high operand bits set catches a vector that is not truncated. A frame whose flags word is rewritten before return checks that flags are loaded from the delayed read data and not from the strobe cycle. A start injected mid-operation and an undefined code check that no second operation or stray state change slips through.

// File: rtl/callret_seq.sv
module callret_seq #(
  parameter int W = 16,
  parameter int FW = 4,
  parameter int VW = 8,
  parameter logic [W-1:0] PC_RST = '0,
  parameter logic [W-1:0] SP_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [W-1:0]  operand,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  pc,
  output logic [W-1:0]  sp,
  output logic [FW-1:0] flags,
  output logic          int_en,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr
);
  localparam int EXEC = 8;
  localparam int CW = $clog2(EXEC);
  localparam logic [2:0] OP_CALL = 3'd0, OP_CALLR = 3'd1, OP_RET = 3'd2,
                         OP_RETI = 3'd3, OP_SWI = 3'd4;

  logic [CW-1:0] cnt;
  logic [2:0]    op_q;
  logic [W-1:0]  arg_q, target;
  logic          saving, restoring;

  assign saving    = busy && (op_q == OP_CALL || op_q == OP_CALLR || op_q == OP_SWI);
  assign restoring = busy && (op_q == OP_RET || op_q == OP_RETI);
  assign done      = busy && cnt == CW'(EXEC - 1);
  assign mem_addr  = sp;
  assign mem_wr    = saving && (cnt == CW'(0) || cnt == CW'(2));
  assign mem_rd    = restoring && (cnt == CW'(1) || cnt == CW'(4));
  assign mem_wdata = (cnt == CW'(0)) ? pc : {{(W-FW){1'b0}}, flags};

  always_comb begin
    case (op_q)
      OP_CALLR: target = pc + arg_q;
      OP_SWI:   target = {{(W-VW){1'b0}}, arg_q[VW-1:0]};
      default:  target = arg_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      op_q   <= '0;
      arg_q  <= '0;
      pc     <= PC_RST;
      sp     <= SP_RST;
      flags  <= '0;
      int_en <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        op_q  <= op;
        arg_q <= operand;
      end
    end else begin
      cnt <= cnt + CW'(1);
      if (done) busy <= 1'b0;
      if (saving) begin
        if (cnt == CW'(1) || cnt == CW'(3)) sp <= sp - W'(1);
        if (cnt == CW'(4)) pc <= target;
      end
      if (restoring) begin
        if (cnt == CW'(0) || cnt == CW'(3)) sp <= sp + W'(1);
        if (cnt == CW'(2)) flags <= mem_rdata[FW-1:0];
        if (cnt == CW'(5)) pc <= mem_rdata;
        if (done && op_q == OP_RETI) int_en <= 1'b1;
      end
    end
  end
endmodule

module callret_chk #(
  parameter int W = 16,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  sp,
  input logic [FW-1:0] flags,
  input logic          int_en,
  input logic          mem_rd,
  input logic          mem_wr
);
  AST_NO_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));                                            // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);                                    // R9
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(start, 8) && !$past(busy, 8)));                  // R2
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);                                                 // R2
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (sp == $past(sp) + W'(1) || sp == $past(sp) - W'(1))); // R3
  AST_FLAGS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags) |-> busy);                                       // R8
  AST_IE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_en) |-> $past(done));                                  // R7
endmodule

bind callret_seq callret_chk #(.W(W), .FW(FW)) u_chk (.*);

// File: tb/sim_callret_seq.sv
`timescale 1ns/1ps
module sim_callret_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op_i = 0;
  logic [15:0] arg_i = 0;
  logic busy, done, int_en, mem_rd, mem_wr;
  logic [15:0] pc, sp, mem_addr, mem_wdata, mem_rdata = 0;
  logic [3:0] flags;

  callret_seq u0 (.clk, .rst_n, .start, .op(op_i), .operand(arg_i), .busy, .done,
    .pc, .sp, .flags, .int_en, .mem_addr, .mem_wdata, .mem_rdata, .mem_rd, .mem_wr);

  always #2.5 clk = ~clk;

  logic [15:0] mem [256];
  int tick = 0, wn = 0, rn = 0;
  int wt [64], rt [64];
  logic [15:0] wa [64], wd [64], ra [64];
  always @(posedge clk) begin
    tick <= tick + 1;
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wa[wn] <= mem_addr; wd[wn] <= mem_wdata; wt[wn] <= tick; wn <= wn + 1;
    end
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[7:0]];
      ra[rn] <= mem_addr; rt[rn] <= tick; rn <= rn + 1;
    end
  end

  int checks = 0, errs = 0;
  logic [15:0] mpc = 16'h0000, msp = 16'hFFFF;
  logic [3:0] mf = 0;
  logic mie = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [15:0] arg, input bit inj);
    int s, wb, rb, n;
    logic [15:0] epc, esp;
    logic [3:0] ef;
    @(negedge clk);
    op_i = op; arg_i = arg; start = 1; s = tick; wb = wn; rb = rn;
    @(negedge clk);
    start = 0; n = 1;
    while (!done && n < 20) begin
      start = inj && n == 3;
      if (inj && n == 3) begin op_i = 3'd4; arg_i = 16'h0077; end
      @(negedge clk);
      n++;
    end
    start = 0;
    chk(n == 8, "R2 done cycle", n, 8);
    @(negedge clk);
    chk(!busy, "R2 idle after done", busy, 0);
    epc = mpc; esp = msp; ef = mf;
    if (op == 0 || op == 1 || op == 4) begin
      chk(wn - wb == 2 && rn == rb, "R3 write count", wn - wb, 2);
      chk(wa[wb] == msp && wd[wb] == mpc && wt[wb] - s - 1 == 0, "R3 pc save", wa[wb], msp);
      chk(wa[wb+1] == msp - 16'd1 && wd[wb+1] == {12'd0, mf} && wt[wb+1] - s - 1 == 2,
          "R3 flags save", wa[wb+1], msp - 16'd1);
      esp = msp - 16'd2;
      if (op == 0) epc = arg;
      else if (op == 1) epc = mpc + arg;
      else epc = {8'd0, arg[7:0]};
      chk(pc == epc, op == 4 ? "R5 vector" : "R4 target", pc, epc);
      chk(flags == mf, "R8 flags kept", flags, mf);
    end else if (op == 2 || op == 3) begin
      chk(rn - rb == 2 && wn == wb, "R6 read count", rn - rb, 2);
      chk(ra[rb] == msp + 16'd1 && rt[rb] - s - 1 == 1, "R6 flags read", ra[rb], msp + 16'd1);
      chk(ra[rb+1] == msp + 16'd2 && rt[rb+1] - s - 1 == 4, "R6 pc read", ra[rb+1], msp + 16'd2);
      ef = mem[8'(msp + 16'd1)][3:0];
      epc = mem[8'(msp + 16'd2)];
      esp = msp + 16'd2;
      chk(pc == epc, "R6 pc restore", pc, epc);
      chk(flags == ef, "R6 flags restore", flags, ef);
      if (op == 3) mie = 1;
    end else begin
      chk(wn == wb && rn == rb, "R10 no access", wn - wb + rn - rb, 0);
      chk(pc == mpc && flags == mf, "R10 state kept", pc, mpc);
    end
    chk(sp == esp, "R3 R6 sp", sp, esp);
    chk(int_en == mie, "R7 int_en", int_en, mie);
    mpc = epc; msp = esp; mf = ef;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
    repeat (3) @(negedge clk);
    chk(pc == 0 && sp == 16'hFFFF && flags == 0, "R1 regs", sp, 16'hFFFF);
    chk(!int_en && !busy && !mem_rd && !mem_wr, "R1 control", int_en, 0);
    rst_n = 1;
    for (int i = 0; i < 6; i++) run(3'd0, 16'h0100 + 16'(i) * 16'h0111, i == 2);
    run(3'd1, 16'h0005, 0);
    run(3'd1, 16'hFFF0, 0);
    run(3'd0, 16'hFFFE, 0);
    run(3'd1, 16'h0004, 0);
    run(3'd4, 16'h0000, 0);
    run(3'd4, 16'h00FF, 0);
    run(3'd4, 16'hAB5A, 0);
    for (int c = 5; c < 8; c++) run(3'(c), 16'h1234, 0);
    for (int i = 0; i < 4; i++) run(3'd2, 16'h0, 0);
    @(negedge clk);
    mem[8'(msp + 16'd1)] = 16'hFFF9;
    run(3'd2, 16'h0, 0);
    mem[8'(msp + 16'd1)] = 16'h0006;
    run(3'd0, 16'h4000, 0);
    run(3'd3, 16'h0, 0);
    for (int i = 0; i < 8; i++) run(3'd2, 16'h0, 0);
    run(3'd4, 16'h0033, 0);
    run(3'd7, 16'h0, 0);
    run(3'd2, 16'h0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    #500000;
    errs++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule